// File: doc/BRIEF.md
# Pipeline Hazard and Operand Bypass Controller

This block is the data-hazard control for a five-stage in-order pipeline whose stages run fetch, decode, execute, memory, writeback. An ALU result exists at the end of execute but reaches the register file only in writeback. Each cycle the block compares the source register indices of the instruction in decode and of the instruction in execute against the destination indices held in the later pipeline registers. From those comparisons it produces one operand-select code for each ALU input, plus a hold for the program counter, a hold for the fetch/decode register and a bubble request that clears the control bits of the decode/execute register.

A single mode input picks the policy. In bypass mode, results are steered from the EX/MEM or MEM/WB pipeline register into the ALU. The only stall is a single bubble when a decoded instruction reads the destination of a load that sits directly ahead of it in execute. In interlock-only mode no value is ever steered. A decoded instruction is held until its producer has reached writeback: two cycles when the producer is directly ahead, and one cycle when the producer is two ahead. The block is purely combinational. All outputs follow the inputs within the same cycle.

Top module: `hazard_ctl`

## Requirements
- R1: Each operand select is 2'b00 for the register-file read, 2'b10 for the EX/MEM value and 2'b01 for the MEM/WB value. The code 2'b11 never appears.
- R2: In bypass mode (`bypass_en`=1), an execute-stage source that matches the EX/MEM destination selects 2'b10. A source that matches only the MEM/WB destination selects 2'b01.
- R3: When EX/MEM and MEM/WB both match the same execute-stage source, the select is 2'b10, because the EX/MEM producer is the more recent one.
- R4: A destination counts as a match only if its write enable is 1 and its index is not register zero. This holds for both the selects and the stalls.
- R5: In bypass mode, a decode-stage source that matches the destination of a load in execute (`ex_mread`=1) raises a stall for exactly that cycle. Once the load is in MEM/WB, the consumer in execute selects 2'b01.
- R6: In bypass mode, a producer that is not a load never causes a stall, whether it is in execute or in memory.
- R7: In interlock-only mode (`bypass_en`=0), both selects are 2'b00. A decode-stage source that matches the execute-stage destination raises a stall.
- R8: In interlock-only mode, a decode-stage source that matches the EX/MEM destination raises a stall. Together with R7, this gives two stall cycles for an adjacent producer and one for a producer two ahead.
- R9: A decode-stage source that matches only the MEM/WB destination causes no stall in either mode.
- R10: A stall drives `pc_hold`, `fd_hold` and `dx_bubble` high together. Otherwise all three are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bypass_en | input | 1 | 1 = bypass with load interlock, 0 = interlock only |
| dec_rs1 | input | RW | First source index of the decode-stage instruction |
| dec_rs2 | input | RW | Second source index of the decode-stage instruction |
| ex_rs1 | input | RW | First source index of the execute-stage instruction |
| ex_rs2 | input | RW | Second source index of the execute-stage instruction |
| ex_rd | input | RW | Destination index of the execute-stage instruction |
| ex_wen | input | 1 | Execute-stage instruction writes a register |
| ex_mread | input | 1 | Execute-stage instruction is a load |
| mem_rd | input | RW | Destination index held in EX/MEM |
| mem_wen | input | 1 | EX/MEM instruction writes a register |
| wb_rd | input | RW | Destination index held in MEM/WB |
| wb_wen | input | 1 | MEM/WB instruction writes a register |
| sel_a | output | 2 | Operand A select code |
| sel_b | output | 2 | Operand B select code |
| pc_hold | output | 1 | Freeze the program counter |
| fd_hold | output | 1 | Freeze the fetch/decode register |
| dx_bubble | output | 1 | Clear decode/execute control bits (NOP) |

## Verification
The selects are tried with a match on EX/MEM only, on MEM/WB only, on both at once, and with distinct producers on the two operands. These patterns separate the per-operand compare, the priority order and the encoding. Matches whose write enable is low or whose index is register zero show that both qualifiers gate every compare. The stall is tried with load and non-load producers in execute, in memory and in writeback, under both modes. These patterns tell the load-only interlock of bypass mode apart from the distance-based interlock of stall-only mode, and they show that the writeback distance never stalls. The state after the load bubble confirms that the loaded value is taken from MEM/WB.

// File: rtl/hazard_ctl.sv
module hazard_ctl #(
  parameter int RW = 5
) (
  input  logic          bypass_en,
  input  logic [RW-1:0] dec_rs1,
  input  logic [RW-1:0] dec_rs2,
  input  logic [RW-1:0] ex_rs1,
  input  logic [RW-1:0] ex_rs2,
  input  logic [RW-1:0] ex_rd,
  input  logic          ex_wen,
  input  logic          ex_mread,
  input  logic [RW-1:0] mem_rd,
  input  logic          mem_wen,
  input  logic [RW-1:0] wb_rd,
  input  logic          wb_wen,
  output logic [1:0]    sel_a,
  output logic [1:0]    sel_b,
  output logic          pc_hold,
  output logic          fd_hold,
  output logic          dx_bubble
);

  localparam logic [1:0] SEL_RF  = 2'b00;
  localparam logic [1:0] SEL_MEM = 2'b10;
  localparam logic [1:0] SEL_WB  = 2'b01;

  function automatic logic hit(input logic wen, input logic [RW-1:0] rd,
                               input logic [RW-1:0] rs);
    return wen && (rd != '0) && (rd == rs);
  endfunction

  function automatic logic [1:0] pick(input logic [RW-1:0] rs);
    if (hit(mem_wen, mem_rd, rs))     return SEL_MEM;
    else if (hit(wb_wen, wb_rd, rs))  return SEL_WB;
    else                              return SEL_RF;
  endfunction

  logic ex_dep, mem_dep, stall;

  assign ex_dep  = hit(ex_wen, ex_rd, dec_rs1)   || hit(ex_wen, ex_rd, dec_rs2);
  assign mem_dep = hit(mem_wen, mem_rd, dec_rs1) || hit(mem_wen, mem_rd, dec_rs2);

  assign sel_a = bypass_en ? pick(ex_rs1) : SEL_RF;
  assign sel_b = bypass_en ? pick(ex_rs2) : SEL_RF;

  assign stall = bypass_en ? (ex_dep && ex_mread) : (ex_dep || mem_dep);

  assign pc_hold   = stall;
  assign fd_hold   = stall;
  assign dx_bubble = stall;

  always_comb begin
    // R1
    sel_code_chk: assert (sel_a != 2'b11 && sel_b != 2'b11)
      else $error("select code 11 produced");
    // R4
    zero_src_chk: assert ((ex_rs1 != '0 || sel_a == SEL_RF) && (ex_rs2 != '0 || sel_b == SEL_RF))
      else $error("register zero was bypassed");
    // R6
    no_alu_stall_chk: assert (!(bypass_en && !ex_mread) || !pc_hold)
      else $error("stall without a load in bypass mode");
    // R7
    lock_sel_chk: assert (bypass_en || (sel_a == SEL_RF && sel_b == SEL_RF))
      else $error("bypass select in interlock-only mode");
    // R9
    quiet_chk: assert (ex_wen || mem_wen || !pc_hold)
      else $error("stall with no pending writer ahead");
  end

endmodule

// File: tb/hazard_ctl_tb.sv
module hazard_ctl_tb;
  logic clk = 0;
  always #10 clk = ~clk;

  logic       bypass_en, ex_wen, ex_mread, mem_wen, wb_wen;
  logic [4:0] dec_rs1, dec_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
  logic [1:0] sel_a, sel_b;
  logic       pc_hold, fd_hold, dx_bubble;

  hazard_ctl u_dut (.*);

  typedef struct { string req; logic [1:0] a; logic [1:0] b; logic s; } exp_t;
  exp_t q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  task automatic drive(input string req, input logic md,
                       input logic [4:0] d1, d2, x1, x2, xd, input logic xw, xl,
                       input logic [4:0] md_rd, input logic mw,
                       input logic [4:0] w_rd, input logic ww,
                       input logic [1:0] ea, eb, input logic es);
    exp_t e;
    @(posedge clk);
    bypass_en = md; dec_rs1 = d1; dec_rs2 = d2; ex_rs1 = x1; ex_rs2 = x2;
    ex_rd = xd; ex_wen = xw; ex_mread = xl; mem_rd = md_rd; mem_wen = mw;
    wb_rd = w_rd; wb_wen = ww;
    e.req = req; e.a = ea; e.b = eb; e.s = es;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (sel_a !== e.a || sel_b !== e.b || pc_hold !== e.s || fd_hold !== e.s || dx_bubble !== e.s) begin
        fails++;
        $display("FAIL %s: got a=%b b=%b hold=%b%b%b, expected a=%b b=%b stall=%b",
                 e.req, sel_a, sel_b, pc_hold, fd_hold, dx_bubble, e.a, e.b, e.s);
      end
    end
  end

  initial begin
    // idle state: R1 R10
    drive("R1 idle", 1, 0,0, 0,0, 0,0,0, 0,0, 0,0, 2'b00,2'b00,0);
    // R2
    drive("R2 exmem to a", 1, 1,2, 3,9, 0,0,0, 3,1, 0,0, 2'b10,2'b00,0);
    drive("R2 memwb to b", 1, 1,2, 9,4, 0,0,0, 0,0, 4,1, 2'b00,2'b01,0);
    drive("R2 split a/b",  1, 1,2, 8,12, 0,0,0, 8,1, 12,1, 2'b10,2'b01,0);
    // R3
    drive("R3 priority", 1, 1,2, 5,5, 0,0,0, 5,1, 5,1, 2'b10,2'b10,0);
    // R4
    drive("R4 rd zero",  1, 1,2, 0,0, 0,0,0, 0,1, 0,1, 2'b00,2'b00,0);
    drive("R4 wen low",  1, 1,2, 3,3, 0,0,0, 3,0, 3,0, 2'b00,2'b00,0);
    drive("R4 load rd0", 1, 0,0, 1,2, 0,1,1, 0,0, 0,0, 2'b00,2'b00,0);
    drive("R4 lock wen low", 0, 7,7, 1,2, 7,0,0, 7,0, 0,0, 2'b00,2'b00,0);
    // R5
    drive("R5 load-use", 1, 1,6, 9,9, 6,1,1, 0,0, 0,0, 2'b00,2'b00,1);
    drive("R5 after bubble", 1, 11,12, 1,6, 0,0,0, 0,0, 6,1, 2'b00,2'b01,0);
    // R6
    drive("R6 alu in ex", 1, 6,2, 9,9, 6,1,0, 0,0, 0,0, 2'b00,2'b00,0);
    drive("R6 alu in mem", 1, 1,7, 9,9, 0,0,0, 7,1, 0,0, 2'b00,2'b00,0);
    // R7
    drive("R7 lock ex dep", 0, 7,2, 3,4, 7,1,0, 3,1, 4,1, 2'b00,2'b00,1);
    // R8
    drive("R8 lock mem dep", 0, 1,7, 9,9, 0,0,0, 7,1, 0,0, 2'b00,2'b00,1);
    // R9
    drive("R9 lock wb only", 0, 7,1, 9,9, 0,0,0, 0,0, 7,1, 2'b00,2'b00,0);
    drive("R9 bypass wb only", 1, 7,1, 9,9, 0,0,0, 0,0, 7,1, 2'b00,2'b00,0);
    // R10 covered by every stall check above
    @(posedge clk);
    wait (q.size() == 0);
    @(posedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule